// File: doc/BRIEF.md
# Clock Calendar Counter with Snapshot

This block keeps wall-clock time and a calendar date. A prescaler counts pulses of a reference strobe (nominally one per 32.768 kHz cycle) and produces a one-second advance. The advance drives a chain of BCD counters for seconds, minutes, hours, day-of-week, date, month and two-digit year. The chain applies the correct month lengths and inserts 29 February in every year whose two-digit value is a multiple of four. That rule is exact for years 2000 through 2099.

A host loads any single field through a write port. A load restarts the prescaler, so the first second after it is a whole second long. Reads never come from the running counters. A capture strobe copies every field at once into a holding register, and the read port selects a byte from that copy. The counters keep running while the host reads, and a multi-byte read stays coherent because every byte comes from the same instant.

A power-loss flag comes up with reset and tells the host that the time is not valid. It is visible in a status byte. The host cannot set it, and the first load of any time field clears it.

Top module: `clock_calendar`

## Requirements
- R1: After reset the fields read 00 s, 00 min, 00 h, day-of-week 0, date 01, month 01 and year 00. The power-loss flag is 1.
- R2: Seconds advance once for every TICK_DIV pulses of ref_tick. Cycles without ref_tick do not count toward the second.
- R3: Seconds wrap from 59 to 00 and minutes wrap from 59 to 00, each carrying into the next field. Hours count 00 to 23 in BCD, and the wrap from 23 to 00 starts a new day.
- R4: Each new day increments day-of-week, which wraps from 6 to 0, and increments the date.
- R5: Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31. Passing the last day sets the date to 01 and increments the month.
- R6: February has 29 days when the year value is a multiple of 4 (00, 24, ...) and 28 days otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: A write with wr_sel codes 0 sec, 1 min, 2 hour, 3 day-of-week, 4 date, 5 month or 6 year loads wr_data into that field and clears the prescaler. A write takes priority over a ref_tick in the same cycle, and that tick does not advance time.
- R8: A seconds value of 0x59 or above, including values that are not valid BCD, becomes 00 on the next advance and carries into minutes.
- R9: snap_req copies all seven live fields into the holding register in one cycle. rd_data returns the held field selected by rd_sel (same codes as R7). The held values do not change until the next snap_req, even while the live time advances.
- R10: rd_sel code 7 returns the status byte. Bit 0 is the live power-loss flag and bits 7:1 are 0.
- R11: A write to any field code 0 to 6 clears the power-loss flag. A write with wr_sel 7 changes no field, does not clear the flag and does not clear the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field code for the write |
| wr_data | input | 8 | BCD value to load |
| snap_req | input | 1 | Capture all live fields into the holding register |
| rd_sel | input | 3 | Field code for the read |
| rd_data | output | 8 | Selected held field, or the status byte for code 7 |
| pwr_fail | output | 1 | Power-loss flag |

## Verification
The directed cases hit each rollover boundary: 23:59:59 into a new day, 28 February in a common year and in a leap year, the 30th of a 30-day month and 31 December 99. A chain with a wrong month table or leap test would land on the wrong date or leave the month unchanged. A write coincident with a final prescaler pulse checks that the pulse is discarded; a design that let it through would show a second that starts one second early. A capture followed by several seconds of counting catches a holding register that follows the live counters. An out-of-range seconds load catches a design that counts past 59. Long random runs with mixed writes and captures are compared field by field against a calendar computed in binary by the bench.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

   localparam int SEL_W  = 3;
   localparam int BYTE_W = 8;

   localparam logic [SEL_W-1:0] F_SEC  = 3'd0;
   localparam logic [SEL_W-1:0] F_MIN  = 3'd1;
   localparam logic [SEL_W-1:0] F_HOUR = 3'd2;
   localparam logic [SEL_W-1:0] F_DOW  = 3'd3;
   localparam logic [SEL_W-1:0] F_DATE = 3'd4;
   localparam logic [SEL_W-1:0] F_MON  = 3'd5;
   localparam logic [SEL_W-1:0] F_YEAR = 3'd6;
   localparam logic [SEL_W-1:0] F_STAT = 3'd7;

   typedef struct packed {
      logic [BYTE_W-1:0] year;
      logic [BYTE_W-1:0] mon;
      logic [BYTE_W-1:0] date;
      logic [BYTE_W-1:0] dow;
      logic [BYTE_W-1:0] hour;
      logic [BYTE_W-1:0] min;
      logic [BYTE_W-1:0] sec;
   } cal_t;

   localparam cal_t CAL_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                  dow: 8'h00, hour: 8'h00, min: 8'h00,
                                  sec: 8'h00};

   // two-digit BCD increment, low digit 9 carries into the high digit
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // leap when (10*hi + lo) mod 4 == 0, i.e. (2*hi + lo) mod 4 == 0
   function automatic logic is_leap(input logic [7:0] yr);
      logic [4:0] s;
      s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] mon,
                                           input logic [7:0] yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
   parameter int TICK_DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic clr,
   output logic sec_tick
);
   localparam int  CNT_W  = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam bit  IS_POW2 = ((TICK_DIV & (TICK_DIV - 1)) == 0);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last  = (cnt_q == LAST);
   assign sec_tick = ref_tick & ~clr & at_last;

   generate
      if (IS_POW2) begin : g_pow2
         // counter wraps on its own width
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clr)      cnt_q <= '0;
            else if (ref_tick) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clr)      cnt_q <= '0;
            else if (ref_tick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/cal_chain.sv
`timescale 1ns/1ps
module cal_chain
   import cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [SEL_W-1:0]  load_sel,
   input  logic [BYTE_W-1:0] load_data,
   output cal_t              cur
);
   cal_t cur_q, nxt;
   logic c_min, c_hour, c_day, c_mon, c_year;

   always_comb begin
      nxt    = cur_q;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_day  = 1'b0;
      c_mon  = 1'b0;
      c_year = 1'b0;
      if (load) begin
         case (load_sel)
            F_SEC:   nxt.sec  = load_data;
            F_MIN:   nxt.min  = load_data;
            F_HOUR:  nxt.hour = load_data;
            F_DOW:   nxt.dow  = load_data;
            F_DATE:  nxt.date = load_data;
            F_MON:   nxt.mon  = load_data;
            F_YEAR:  nxt.year = load_data;
            default: nxt      = cur_q;
         endcase
      end else if (tick) begin
         if (cur_q.sec >= 8'h59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
         end else begin
            nxt.sec = bcd_inc(cur_q.sec);
         end
         if (c_min) begin
            if (cur_q.min >= 8'h59) begin
               nxt.min = 8'h00;
               c_hour  = 1'b1;
            end else begin
               nxt.min = bcd_inc(cur_q.min);
            end
         end
         if (c_hour) begin
            if (cur_q.hour >= 8'h23) begin
               nxt.hour = 8'h00;
               c_day    = 1'b1;
            end else begin
               nxt.hour = bcd_inc(cur_q.hour);
            end
         end
         if (c_day) begin
            nxt.dow = (cur_q.dow >= 8'h06) ? 8'h00 : cur_q.dow + 8'h01;
            if (cur_q.date >= last_day(cur_q.mon, cur_q.year)) begin
               nxt.date = 8'h01;
               c_mon    = 1'b1;
            end else begin
               nxt.date = bcd_inc(cur_q.date);
            end
         end
         if (c_mon) begin
            if (cur_q.mon >= 8'h12) begin
               nxt.mon = 8'h01;
               c_year  = 1'b1;
            end else begin
               nxt.mon = bcd_inc(cur_q.mon);
            end
         end
         if (c_year) begin
            nxt.year = (cur_q.year >= 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= CAL_RESET;
      else        cur_q <= nxt;
   end

   assign cur = cur_q;

endmodule

// File: rtl/cal_snapshot.sv
`timescale 1ns/1ps
module cal_snapshot
   import cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  cal_t              live,
   input  logic              flag,
   input  logic [SEL_W-1:0]  sel,
   output cal_t              held,
   output logic [BYTE_W-1:0] data
);
   cal_t held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= CAL_RESET;
      else if (capture) held_q <= live;
   end

   always_comb begin
      case (sel)
         F_SEC:   data = held_q.sec;
         F_MIN:   data = held_q.min;
         F_HOUR:  data = held_q.hour;
         F_DOW:   data = held_q.dow;
         F_DATE:  data = held_q.date;
         F_MON:   data = held_q.mon;
         F_YEAR:  data = held_q.year;
         default: data = {{(BYTE_W-1){1'b0}}, flag};
      endcase
   end

   assign held = held_q;

endmodule

// File: rtl/clock_calendar.sv
`timescale 1ns/1ps
module clock_calendar
   import cal_pkg::*;
#(
   parameter int TICK_DIV = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              snap_req,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   output logic              pwr_fail
);
   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("clock_calendar: TICK_DIV must be at least 2");
      end
   endgenerate

   logic field_wr;
   logic sec_tick;
   logic pf_q;
   cal_t live_q;
   cal_t snap_q;

   assign field_wr = wr_en & (wr_sel != F_STAT);

   cal_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .clr      (field_wr),
      .sec_tick (sec_tick)
   );

   cal_chain u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .load      (field_wr),
      .load_sel  (wr_sel),
      .load_data (wr_data),
      .cur       (live_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pf_q <= 1'b1;
      else if (field_wr) pf_q <= 1'b0;
   end

   assign pwr_fail = pf_q;

   cal_snapshot u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (snap_req),
      .live    (live_q),
      .flag    (pf_q),
      .sel     (rd_sel),
      .held    (snap_q),
      .data    (rd_data)
   );

endmodule

// File: rtl/clock_calendar_chk.sv
`timescale 1ns/1ps
module clock_calendar_chk
   import cal_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [SEL_W-1:0]  wr_sel,
   input logic [BYTE_W-1:0] wr_data,
   input logic              snap_req,
   input logic              sec_tick,
   input cal_t              live_q,
   input cal_t              snap_q,
   input logic              pwr_fail
);
   p_load_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == F_SEC) |=> (live_q.sec == $past(wr_data)));

   p_write_blocks_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != F_STAT) |-> !sec_tick);

   p_sec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && live_q.sec >= 8'h59) |=> (live_q.sec == 8'h00));

   p_day_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && live_q.sec == 8'h59 && live_q.min == 8'h59 &&
       live_q.hour == 8'h23) |=> (live_q.hour == 8'h00 && live_q.min == 8'h00));

   p_snap_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (snap_q == $past(live_q)));

   p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snap_q));

   p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != F_STAT) |=> !pwr_fail);

   p_flag_no_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_fail |=> !pwr_fail);

endmodule

bind clock_calendar clock_calendar_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .snap_req (snap_req),
   .sec_tick (sec_tick),
   .live_q   (live_q),
   .snap_q   (snap_q),
   .pwr_fail (pwr_fail)
);

// File: tb/clock_calendar_tb.sv
`timescale 1ns/1ps
module clock_calendar_tb;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       snap_req = 1'b0;
   logic [2:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       pwr_fail;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   clock_calendar #(.TICK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .snap_req(snap_req),
      .rd_sel(rd_sel), .rd_data(rd_data), .pwr_fail(pwr_fail)
   );

   // ---------------- reference calendar, binary arithmetic ----------------
   logic [7:0] mf [7];
   logic [7:0] ms [7];
   int         mcnt;
   bit         mpf;

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int mdays(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic advance();
      bit c;
      int v;
      if (mf[0] >= 8'h59) begin mf[0] = 8'h00; c = 1; end
      else begin mf[0] = i2b(b2i(mf[0]) + 1); c = 0; end
      if (c) begin
         v = b2i(mf[1]);
         if (v >= 59) mf[1] = 8'h00; else begin mf[1] = i2b(v + 1); c = 0; end
      end
      if (c) begin
         v = b2i(mf[2]);
         if (v >= 23) mf[2] = 8'h00; else begin mf[2] = i2b(v + 1); c = 0; end
      end
      if (c) begin
         v = b2i(mf[3]);
         mf[3] = (v >= 6) ? 8'h00 : i2b(v + 1);
         v = b2i(mf[4]);
         if (v >= mdays(b2i(mf[5]), b2i(mf[6]))) mf[4] = 8'h01;
         else begin mf[4] = i2b(v + 1); c = 0; end
      end
      if (c) begin
         v = b2i(mf[5]);
         if (v >= 12) mf[5] = 8'h01; else begin mf[5] = i2b(v + 1); c = 0; end
      end
      if (c) begin
         v = b2i(mf[6]);
         mf[6] = (v >= 99) ? 8'h00 : i2b(v + 1);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mf = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
         ms = mf;
         mcnt = 0;
         mpf = 1'b1;
      end else begin
         if (snap_req) ms = mf;
         if (wr_en && wr_sel != 3'd7) begin
            mf[wr_sel] = wr_data;
            mcnt = 0;
            mpf = 1'b0;
         end else if (ref_tick) begin
            if (mcnt == DIV - 1) begin mcnt = 0; advance(); end
            else mcnt = mcnt + 1;
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input bit r, input bit w, input logic [2:0] s,
                      input logic [7:0] d, input bit sn);
      @(negedge clk);
      ref_tick = r; wr_en = w; wr_sel = s; wr_data = d; snap_req = sn;
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      cyc(0, 1, s, d, 0);
   endtask

   task automatic tickn(input int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 3'd0, 8'h00, 0);
   endtask

   task automatic snap();
      cyc(0, 0, 3'd0, 8'h00, 1);
   endtask

   task automatic rd_begin();
      @(negedge clk);
      ref_tick = 0; wr_en = 0; wr_sel = '0; wr_data = '0; snap_req = 0;
   endtask

   task automatic chk(input logic [2:0] s, input logic [7:0] exp, input string tag);
      rd_sel = s;
      #0.2;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s sel=%0d actual=%02h expected=%02h", tag, s, rd_data, exp);
      end
   endtask

   task automatic cmp_all(input string tag);
      for (int s = 0; s < 8; s++)
         chk(3'(s), (s < 7) ? ms[s] : {7'b0, mpf}, tag);
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                           input logic [7:0] s);
      wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
   endtask

   function automatic logic [7:0] rnd_field(input logic [2:0] s);
      case (s)
         3'd0: return ($urandom % 10 == 0) ? 8'(8'h5A + $urandom % 166)
                                           : i2b($urandom % 60);
         3'd1: return i2b($urandom % 60);
         3'd2: return i2b($urandom % 24);
         3'd3: return i2b($urandom % 7);
         3'd4: return i2b(1 + $urandom % 31);
         3'd5: return i2b(1 + $urandom % 12);
         3'd6: return i2b($urandom % 100);
         default: return 8'($urandom % 256);
      endcase
   endfunction

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R10: reset values and status byte
      rd_begin();
      chk(3'd0, 8'h00, "R1 sec");  chk(3'd1, 8'h00, "R1 min");
      chk(3'd2, 8'h00, "R1 hour"); chk(3'd3, 8'h00, "R1 dow");
      chk(3'd4, 8'h01, "R1 date"); chk(3'd5, 8'h01, "R1 month");
      chk(3'd6, 8'h00, "R1 year"); chk(3'd7, 8'h01, "R10 status");

      // R11: code 7 write is ignored
      wr(3'd7, 8'hFF); snap(); rd_begin();
      chk(3'd7, 8'h01, "R11 flag kept"); chk(3'd0, 8'h00, "R11 sec unchanged");
      wr(3'd0, 8'h00); rd_begin();
      chk(3'd7, 8'h00, "R11 flag cleared");

      // R3 R4 R6: common-year February into March
      set_time(8'h23, 8'h59, 8'h58);
      wr(3'd3, 8'h06); wr(3'd4, 8'h28); wr(3'd5, 8'h02); wr(3'd6, 8'h23);
      tickn(2 * DIV); snap(); rd_begin();
      chk(3'd0, 8'h00, "R3 sec"); chk(3'd1, 8'h00, "R3 min");
      chk(3'd2, 8'h00, "R3 hour"); chk(3'd3, 8'h00, "R4 dow wrap");
      chk(3'd4, 8'h01, "R6 date"); chk(3'd5, 8'h03, "R6 month");

      // R6: leap February
      wr(3'd6, 8'h24); wr(3'd5, 8'h02); wr(3'd4, 8'h28);
      set_time(8'h23, 8'h59, 8'h59);
      tickn(DIV); snap(); rd_begin();
      chk(3'd4, 8'h29, "R6 leap 29"); chk(3'd5, 8'h02, "R6 leap month");
      chk(3'd3, 8'h01, "R4 dow inc");
      set_time(8'h23, 8'h59, 8'h59);
      tickn(DIV); snap(); rd_begin();
      chk(3'd4, 8'h01, "R6 leap rollover"); chk(3'd5, 8'h03, "R6 leap to march");

      // R5: 30-day and 31-day months
      wr(3'd5, 8'h04); wr(3'd4, 8'h30); set_time(8'h23, 8'h59, 8'h59);
      tickn(DIV); snap(); rd_begin();
      chk(3'd4, 8'h01, "R5 apr end"); chk(3'd5, 8'h05, "R5 apr to may");
      wr(3'd4, 8'h30); set_time(8'h23, 8'h59, 8'h59);
      tickn(DIV); snap(); rd_begin();
      chk(3'd4, 8'h31, "R5 may 31"); chk(3'd5, 8'h05, "R5 may stays");

      // R6: year wrap
      wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31);
      set_time(8'h23, 8'h59, 8'h59);
      tickn(DIV); snap(); rd_begin();
      chk(3'd6, 8'h00, "R6 year wrap"); chk(3'd5, 8'h01, "R6 month wrap");
      chk(3'd4, 8'h01, "R6 date wrap");

      // R8: out-of-range seconds
      wr(3'd1, 8'h10); wr(3'd0, 8'h75);
      tickn(DIV); snap(); rd_begin();
      chk(3'd0, 8'h00, "R8 sec wrap"); chk(3'd1, 8'h11, "R8 min carry");

      // R2: exact prescale count, gaps ignored
      wr(3'd0, 8'h10);
      tickn(DIV - 1); cyc(0, 0, 3'd0, 8'h00, 0); snap(); rd_begin();
      chk(3'd0, 8'h10, "R2 not yet");
      tickn(1); snap(); rd_begin();
      chk(3'd0, 8'h11, "R2 one second");

      // R7: write beats coincident final pulse, prescaler restarts
      wr(3'd0, 8'h20);
      tickn(DIV - 1); cyc(1, 1, 3'd1, 8'h30, 0); snap(); rd_begin();
      chk(3'd0, 8'h20, "R7 tick dropped"); chk(3'd1, 8'h30, "R7 min loaded");
      tickn(DIV - 1); snap(); rd_begin();
      chk(3'd0, 8'h20, "R7 full second");
      tickn(1); snap(); rd_begin();
      chk(3'd0, 8'h21, "R7 after restart");

      // R9: held copy ignores live advance
      set_time(8'h05, 8'h06, 8'h07); snap();
      tickn(3 * DIV); rd_begin();
      chk(3'd0, 8'h07, "R9 held sec"); chk(3'd2, 8'h05, "R9 held hour");
      snap(); rd_begin();
      chk(3'd0, 8'h10, "R9 new capture");
      cmp_all("R9 model");

      // random phase
      for (int it = 0; it < 6000; it++) begin
         bit          r, w, sn;
         logic [2:0]  s;
         logic [7:0]  d;
         r  = ($urandom % 100) < 70;
         w  = ($urandom % 30) == 0;
         s  = 3'($urandom % 8);
         d  = rnd_field(s);
         sn = ($urandom % 25) == 0;
         cyc(r, w, s, d, sn);
         if (it % 150 == 149) begin
            snap(); rd_begin();
            cmp_all("R9 random");
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule